// File: doc/BRIEF.md
# Cascadable 4-Bit Shifter Slice

This block is a purely combinational shifter slice. It takes a 4-bit data word and moves it toward the higher bit index by 0, 1, 2 or 3 places, chosen by a 2-bit shift code. The bit positions vacated at the bottom are filled from three link inputs. These link inputs carry the three next lower-order bits of a wider word, taken from the neighbouring slice below. Chaining slices in this way builds shifters of any word length. Zero-fill, sign-fill or rotation comes from what the system wires into the link inputs of the lowest slice.

An active-low output enable gates the result. When the slice is disabled, it drives an all-zero word and lowers its drive flag. Several slices can then share one result bus that is modelled as an OR of their outputs. Shifts larger than three places use this: the enables act as a further level of selection between slices that are wired to different offsets.

Top module: `shf_slice`

## Requirements
- R1: With i_oe_n = 0 and i_shift = 0, o_data equals i_data.
- R2: With i_oe_n = 0 and i_shift = 1, o_data = {i_data[2:0], i_link[2]}.
- R3: With i_oe_n = 0 and i_shift = 2, o_data = {i_data[1:0], i_link[2], i_link[1]}.
- R4: With i_oe_n = 0 and i_shift = 3, o_data = {i_data[0], i_link[2], i_link[1], i_link[0]}.
- R5: With i_oe_n = 1, o_data is 4'b0000 and o_drive is 0, whatever i_data, i_link and i_shift are.
- R6: With i_oe_n = 0, o_drive is 1.
- R7: i_link[2] is the bit just below i_data[0], and i_link[0] is three places below it. With i_shift = 0, the link inputs have no effect on o_data.
- R8: The slice has no state. o_data and o_drive follow a change at any input in the same time step, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| i_data | input | 4 | Data word to be shifted |
| i_link | input | 3 | Next lower-order bits; bit 2 is the nearest |
| i_shift | input | 2 | Shift amount, 0 to 3 places toward the higher index |
| i_oe_n | input | 1 | Active-low output enable |
| o_data | output | 4 | Shifted word, or zero when disabled |
| o_drive | output | 1 | High when the slice drives the result bus |

## Verification
The hardest case to reach is the deepest link bit, i_link[0]. It reaches the output only at shift 3 and only on bit 0. A fault in its routing stays hidden unless that select code is applied together with a link pattern in which that bit differs from its neighbours. The stimulus therefore sweeps all 128 combinations of data and link bits under every shift code, with the slice both enabled and disabled. It also changes inputs between clock edges to show that the outputs respond without a clock.

// File: rtl/shf_pkg.sv
// Package shf_pkg: shared sizes for the shifter slice.
// Assumes a slice width that is a power of two, so that the shift code
// covers every leg of each bit multiplexer exactly.
package shf_pkg;
    localparam int SLICE_W = 4;
    localparam int SEL_W   = $clog2(SLICE_W);
    localparam int LINK_W  = SLICE_W - 1;
    localparam int EXT_W   = SLICE_W + LINK_W;
endpackage

// File: rtl/shf_mux.sv
// Module shf_mux: one output bit, chosen from N legs by a binary select.
// Assumes N equals 2**SEL_W; leg k is picked when i_sel equals k.
module shf_mux #(
    parameter int N     = 4,
    parameter int SEL_W = 2
) (
    input  logic [N-1:0]     i_leg,
    input  logic [SEL_W-1:0] i_sel,
    output logic             o_bit
);
    // Pick the addressed leg.
    always_comb begin
        o_bit = i_leg[i_sel];
    end
endmodule

// File: rtl/shf_gate.sv
// Module shf_gate: output enable stage. When disabled, it forces the word
// to zero so that an OR-combined bus is not disturbed, and it lowers the
// drive flag. Assumes an active-low enable.
module shf_gate #(
    parameter int W = 4
) (
    input  logic [W-1:0] i_word,
    input  logic         i_oe_n,
    output logic [W-1:0] o_word,
    output logic         o_drive
);
    // Gate the word and report drive state.
    always_comb begin
        o_drive = ~i_oe_n;
        o_word  = i_oe_n ? '0 : i_word;
    end
endmodule

// File: rtl/shf_slice.sv
// Module shf_slice: combinational cascadable shifter slice. The data word
// is joined below by the link bits, giving one extended vector. Output bit
// n at shift k takes extended bit n + LINK_W - k, so each step of the
// select moves the word up by one place. No clock and no state.
// Assumes SLICE_W is a power of two and LINK_W = SLICE_W - 1.
module shf_slice
    import shf_pkg::*;
#(
    parameter int W  = SLICE_W,
    localparam int SW = $clog2(W),
    localparam int LW = W - 1,
    localparam int XW = W + LW
) (
    input  logic [W-1:0]  i_data,
    input  logic [LW-1:0] i_link,
    input  logic [SW-1:0] i_shift,
    input  logic          i_oe_n,
    output logic [W-1:0]  o_data,
    output logic          o_drive
);
    logic [XW-1:0]       ext;
    logic [W-1:0][W-1:0] leg;
    logic [W-1:0]        shifted;

    // Join the data word above its lower-order link bits.
    always_comb begin
        ext = {i_data, i_link};
    end

    // One multiplexer per output bit, legs wired one place apart.
    for (genvar n = 0; n < W; n++) begin : g_bit
        for (genvar k = 0; k < W; k++) begin : g_leg
            assign leg[n][k] = ext[n + LW - k];
        end
        shf_mux #(.N(W), .SEL_W(SW)) u_mux (
            .i_leg (leg[n]),
            .i_sel (i_shift),
            .o_bit (shifted[n])
        );
    end

    shf_gate #(.W(W)) u_gate (
        .i_word  (shifted),
        .i_oe_n  (i_oe_n),
        .o_word  (o_data),
        .o_drive (o_drive)
    );
endmodule

// File: rtl/shf_slice_chk.sv
// Module shf_slice_chk: checker bound to shf_slice. The slice has no clock,
// so the checks are immediate assertions evaluated whenever a port changes.
module shf_slice_chk (
    input logic [3:0] i_data,
    input logic [2:0] i_link,
    input logic [1:0] i_shift,
    input logic       i_oe_n,
    input logic [3:0] o_data,
    input logic       o_drive
);
    // Compare port values against each requirement.
    always_comb begin
        if (!i_oe_n && i_shift == 2'd0) begin
            p_pass_r1: assert (o_data == i_data);
        end
        if (!i_oe_n && i_shift == 2'd1) begin
            p_up1_r2: assert (o_data[3:1] == i_data[2:0] && o_data[0] == i_link[2]);
        end
        if (!i_oe_n && i_shift == 2'd2) begin
            p_up2_r3: assert (o_data[3:2] == i_data[1:0] && o_data[1:0] == i_link[2:1]);
        end
        if (!i_oe_n && i_shift == 2'd3) begin
            p_up3_r4: assert (o_data[3] == i_data[0] && o_data[2:0] == i_link);
        end
        if (i_oe_n) begin
            p_quiet_r5: assert (o_data == 4'b0000 && !o_drive);
        end
        if (!i_oe_n) begin
            p_drive_r6: assert (o_drive);
        end
    end
endmodule

bind shf_slice shf_slice_chk u_chk (
    .i_data  (i_data),
    .i_link  (i_link),
    .i_shift (i_shift),
    .i_oe_n  (i_oe_n),
    .o_data  (o_data),
    .o_drive (o_drive)
);

// File: tb/shf_slice_bench.sv
// Bench for shf_slice: directed tasks, each one checking its own results.
module shf_slice_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] i_data = '0;
    logic [2:0] i_link = '0;
    logic [1:0] i_shift = '0;
    logic       i_oe_n = 1'b1;
    logic [3:0] o_data;
    logic       o_drive;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    shf_slice u_shf_slice (
        .i_data  (i_data),
        .i_link  (i_link),
        .i_shift (i_shift),
        .i_oe_n  (i_oe_n),
        .o_data  (o_data),
        .o_drive (o_drive)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Expected word, written per requirement R1 to R4.
    function automatic logic [3:0] expect_word(logic [3:0] d, logic [2:0] l, logic [1:0] s);
        case (s)
            2'd0:    return d;
            2'd1:    return {d[2:0], l[2]};
            2'd2:    return {d[1:0], l[2], l[1]};
            default: return {d[0], l[2], l[1], l[0]};
        endcase
    endfunction

    task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic apply(logic [3:0] d, logic [2:0] l, logic [1:0] s, logic oe_n);
        @(negedge clk);
        i_data = d; i_link = l; i_shift = s; i_oe_n = oe_n;
        #1;
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Reset state: disabled slice drives nothing (R5).
    task automatic t_reset();
        apply(4'hF, 3'h7, 2'd2, 1'b1);
        chk("R5 reset data", o_data, 4'h0);
        chk("R5 reset drive", {3'b0, o_drive}, 4'h0);
    endtask

    // Every data/link pattern under every shift, enabled (R1-R4, R6).
    task automatic t_enabled_sweep();
        for (int p = 0; p < 128; p++) begin
            for (int s = 0; s < 4; s++) begin
                apply(p[6:3], p[2:0], s[1:0], 1'b0);
                case (s)
                    0: chk("R1 shift0", o_data, expect_word(p[6:3], p[2:0], 2'd0));
                    1: chk("R2 shift1", o_data, expect_word(p[6:3], p[2:0], 2'd1));
                    2: chk("R3 shift2", o_data, expect_word(p[6:3], p[2:0], 2'd2));
                    default: chk("R4 shift3", o_data, expect_word(p[6:3], p[2:0], 2'd3));
                endcase
                chk("R6 drive", {3'b0, o_drive}, 4'h1);
            end
        end
    endtask

    // Every pattern disabled: output stays zero (R5).
    task automatic t_disabled_sweep();
        for (int p = 0; p < 128; p++) begin
            for (int s = 0; s < 4; s++) begin
                apply(p[6:3], p[2:0], s[1:0], 1'b1);
                chk("R5 data", o_data, 4'h0);
                chk("R5 drive", {3'b0, o_drive}, 4'h0);
            end
        end
    endtask

    // Link ordering and no link effect at shift 0 (R7).
    task automatic t_link_order();
        apply(4'b0000, 3'b100, 2'd1, 1'b0);
        chk("R7 nearest link at shift1", o_data, 4'b0001);
        apply(4'b0000, 3'b001, 2'd3, 1'b0);
        chk("R7 deepest link at shift3", o_data, 4'b0001);
        apply(4'b0000, 3'b001, 2'd1, 1'b0);
        chk("R7 deepest link hidden at shift1", o_data, 4'b0000);
        apply(4'b1010, 3'b000, 2'd0, 1'b0);
        chk("R7 shift0 links low", o_data, 4'b1010);
        i_link = 3'b111;
        #1;
        chk("R7 shift0 links high", o_data, 4'b1010);
    endtask

    // Outputs follow inputs between clock edges (R8).
    task automatic t_no_clock();
        @(posedge clk);
        #1;
        i_oe_n = 1'b0; i_shift = 2'd2; i_data = 4'b0110; i_link = 3'b010;
        #1;
        chk("R8 follow data", o_data, 4'b1001);
        i_shift = 2'd3;
        #1;
        chk("R8 follow shift", o_data, 4'b0010);
        i_oe_n = 1'b1;
        #1;
        chk("R8 follow enable", {o_drive, o_data[2:0]}, 4'b0000);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            report();
        end
    end

    // Test sequence.
    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enabled_sweep();
        t_disabled_sweep();
        t_link_order();
        t_no_clock();
        done = 1'b1;
        report();
    end
endmodule